// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control core of a register-rename pipeline stage. Each cycle it receives an instruction group of up to `W` slots from decode, together with stall, squash and free-entry information from the stages behind it. It decides how many instructions move on this cycle and which ones. It decides whether decode must be held off, and whether the incoming group has to be parked in a small skid buffer until the stage can take it. The operand renaming itself is not done here. The only contact with the map and free list is a count of free physical registers. That count is compared against the destination count of each instruction.

The controller runs in one of four modes: running, blocked, unblocking and squashing. Free-entry counts for the reorder buffer and the issue queue are reduced by the number of instructions that may already be in flight (`W * DLY`) before they are used as credits. A group can be accepted in part. When that happens the stage keeps a slot index, so the rest of the group resumes at the right instruction once the stage restarts from the skid buffer.

Top module: `rn_stall_ctrl`

## Requirements
- R1: After reset the mode output is 0 (running), `stall_dec` is low and `out_cnt` is 0.
- R2: In running mode with no stall, no squash and ample credits, every non-squashed slot of the decode group below `dec_cnt` is emitted in the same cycle, in slot order, packed into the lowest slots of `out_tag` (slot k in bits k*TW upward), with `out_cnt` giving the count.
- R3: A slot whose `dec_sqd` bit is set is dropped. It produces no output and uses no credit, so a group whose live slots fit the credit is not blocked by its squashed slots.
- R4: The usable credit is the smaller of `rob_free - W*DLY` and `iq_free - W*DLY`. `out_cnt` never exceeds it. If it is zero or negative, nothing is emitted and the mode becomes 1 (blocked).
- R5: If the credit is positive but smaller than the live slots, exactly that many are emitted and the stage blocks. After unblocking, renaming resumes at the first slot not yet taken.
- R6: Physical registers are counted down within the cycle by each emitted instruction's destination count (`dec_dst`, DW bits per slot). Renaming stops at the first instruction whose count exceeds what is left, the stage blocks, and that instruction is the first one emitted after unblocking.
- R7: A stall from the execute side (`iew_stall`) or from commit (`cmt_stall`) blocks the stage with nothing emitted. Groups that arrive while blocked are stored and later emitted in arrival order.
- R8: Blocked mode moves to unblocking (mode 2) only when both stalls are low, both credits are positive and `preg_free` is non-zero. It moves straight to running when nothing is stored.
- R9: In unblocking mode, stored groups are drained oldest first before any new input, and `stall_dec` stays high. Once the last stored group is done, the mode returns to 0 and `stall_dec` falls.
- R10: `cmt_squash` or `cmt_rob_sq` discards all stored groups and the current group, resets the slot index, emits nothing and enters mode 3 (squashing). Squashing ends in the first cycle with both low, and that cycle handles its decode group as running mode would.
- R11: Every non-squashed instruction handed in before a squash leaves the block exactly once and in order. Nothing handed in before a squash leaves after it.
- R12: `stall_dec` is a registered output that is high in the cycle after any cycle ending in blocked or unblocking mode. The skid buffer never overflows when decode reacts to `stall_dec` one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_cnt | input | CNTW | Number of valid slots in the decode group (0 = none) |
| dec_tag | input | W*TW | Per-slot instruction tag |
| dec_sqd | input | W | Per-slot already-squashed flag |
| dec_dst | input | W*DW | Per-slot destination register count |
| iew_stall | input | 1 | Stall from the execute side |
| cmt_stall | input | 1 | Stall from commit |
| cmt_squash | input | 1 | Squash request from commit |
| cmt_rob_sq | input | 1 | Reorder buffer still squashing |
| rob_free | input | FRW | Free reorder buffer entries reported |
| iq_free | input | FRW | Free issue queue entries reported |
| preg_free | input | PW | Free physical registers |
| out_cnt | output | CNTW | Instructions emitted this cycle |
| out_tag | output | W*TW | Emitted tags, packed from slot 0 |
| stall_dec | output | 1 | Hold request toward decode |
| mode | output | 2 | 0 running, 1 blocked, 2 unblocking, 3 squashing |

## Verification
The bound checker watches several rules on every cycle: silence in blocked mode and during a squash, entry into squashing after any squash indication, the credit bound on `out_cnt`, an empty store in running mode and a non-empty one while unblocking, and the absence of overflow. The order and completeness of the instruction stream can only be seen across whole scenarios. So can resumption at the saved slot, the unblock conditions and the drain order. The bench follows these with a tag scoreboard through directed sequences and a long run of random stalls, credit starvation and squashes.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    RN_RUN = 2'd0,
    RN_BLK = 2'd1,
    RN_UNB = 2'd2,
    RN_SQ  = 2'd3
  } rn_mode_e;
endpackage

// File: rtl/rn_credit.sv
// Credit computation: reported free entries minus in-flight reservation.
module rn_credit #(
  parameter int W    = 4,
  parameter int DLY  = 1,
  parameter int FRW  = 6,
  parameter int CNTW = 3
) (
  input  logic [FRW-1:0]  rob_free,
  input  logic [FRW-1:0]  iq_free,
  output logic            cred_ok,
  output logic [CNTW-1:0] cred_lim
);
  localparam int CW = FRW + 2;
  localparam logic signed [CW-1:0] RSV = CW'(W * DLY);
  localparam logic signed [CW-1:0] WSG = CW'(W);

  logic signed [CW-1:0] rob_c;
  logic signed [CW-1:0] iq_c;
  logic signed [CW-1:0] low_c;

  assign rob_c = $signed({2'b00, rob_free}) - RSV;
  assign iq_c  = $signed({2'b00, iq_free}) - RSV;
  assign low_c = (rob_c < iq_c) ? rob_c : iq_c;

  assign cred_ok = (rob_c > 0) && (iq_c > 0);

  always_comb begin
    if (!cred_ok) begin
      cred_lim = '0;
    end else if (low_c >= WSG) begin
      cred_lim = CNTW'(W);
    end else begin
      cred_lim = low_c[CNTW-1:0];
    end
  end
endmodule

// File: rtl/rn_skid.sv
// Group store used while the stage is blocked; drained oldest first.
module rn_skid #(
  parameter int W    = 4,
  parameter int TW   = 8,
  parameter int DW   = 2,
  parameter int CNTW = 3,
  parameter int SKD  = 4,
  localparam int PTRW = (SKD > 1) ? $clog2(SKD) : 1,
  localparam int SCW  = $clog2(SKD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic            pop,
  input  logic [CNTW-1:0] in_cnt,
  input  logic [W*TW-1:0] in_tag,
  input  logic [W-1:0]    in_sqd,
  input  logic [W*DW-1:0] in_dst,
  output logic [CNTW-1:0] hd_cnt,
  output logic [W*TW-1:0] hd_tag,
  output logic [W-1:0]    hd_sqd,
  output logic [W*DW-1:0] hd_dst,
  output logic [SCW-1:0]  level,
  output logic            full,
  output logic            empty
);
  logic [CNTW-1:0] m_cnt [SKD];
  logic [W*TW-1:0] m_tag [SKD];
  logic [W-1:0]    m_sqd [SKD];
  logic [W*DW-1:0] m_dst [SKD];

  logic [PTRW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [SCW-1:0]  lvl_q, lvl_d;
  logic            do_push, do_pop;

  function automatic logic [PTRW-1:0] nxt_ptr(input logic [PTRW-1:0] p);
    if (p == PTRW'(SKD - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full    = (lvl_q == SCW'(SKD));
  assign empty   = (lvl_q == '0);
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && !clr && (!full || do_pop);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = nxt_ptr(wr_q);
      if (do_pop)  rd_d = nxt_ptr(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  // Storage has no reset; contents are only read when level is non-zero.
  always_ff @(posedge clk) begin
    if (do_push) begin
      m_cnt[wr_q] <= in_cnt;
      m_tag[wr_q] <= in_tag;
      m_sqd[wr_q] <= in_sqd;
      m_dst[wr_q] <= in_dst;
    end
  end

  assign hd_cnt = m_cnt[rd_q];
  assign hd_tag = m_tag[rd_q];
  assign hd_sqd = m_sqd[rd_q];
  assign hd_dst = m_dst[rd_q];
  assign level  = lvl_q;
endmodule

// File: rtl/rn_walk.sv
// Walks the slots of one group from a start index, skipping squashed
// slots, and stops at the first live slot that lacks a credit or enough
// free physical registers.
module rn_walk #(
  parameter int W    = 4,
  parameter int TW   = 8,
  parameter int DW   = 2,
  parameter int PW   = 6,
  parameter int CNTW = 3
) (
  input  logic [CNTW-1:0] src_cnt,
  input  logic [W*TW-1:0] src_tag,
  input  logic [W-1:0]    src_sqd,
  input  logic [W*DW-1:0] src_dst,
  input  logic [CNTW-1:0] start_idx,
  input  logic [CNTW-1:0] cred_lim,
  input  logic [PW-1:0]   preg_free,
  output logic [CNTW-1:0] emit_cnt,
  output logic [W*TW-1:0] emit_tag,
  output logic [CNTW-1:0] stop_idx,
  output logic            grp_done
);
  always_comb begin
    int  cred;
    int  pleft;
    int  k;
    int  need;
    logic halted;
    cred     = int'(cred_lim);
    pleft    = int'(preg_free);
    k        = 0;
    halted   = 1'b0;
    emit_tag = '0;
    stop_idx = src_cnt;
    for (int i = 0; i < W; i++) begin
      need = int'(src_dst[i*DW +: DW]);
      if (!halted && (i >= int'(start_idx)) && (i < int'(src_cnt))) begin
        if (src_sqd[i]) begin
          // dropped slot: consumes input only
        end else if ((cred == 0) || (pleft < need)) begin
          halted   = 1'b1;
          stop_idx = CNTW'(i);
        end else begin
          emit_tag[k*TW +: TW] = src_tag[i*TW +: TW];
          k     = k + 1;
          cred  = cred - 1;
          pleft = pleft - need;
        end
      end
    end
    emit_cnt = CNTW'(k);
    grp_done = !halted;
  end
endmodule

// File: rtl/rn_stall_ctrl.sv
// Rename stage stall controller: mode FSM, skid store, credit limiting.
module rn_stall_ctrl
  import rn_pkg::*;
#(
  parameter int W   = 4,
  parameter int TW  = 8,
  parameter int DW  = 2,
  parameter int DLY = 1,
  parameter int SKD = 4,
  parameter int FRW = 6,
  parameter int PW  = 6,
  localparam int CNTW = $clog2(W + 1),
  localparam int SCW  = $clog2(SKD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] dec_cnt,
  input  logic [W*TW-1:0] dec_tag,
  input  logic [W-1:0]    dec_sqd,
  input  logic [W*DW-1:0] dec_dst,
  input  logic            iew_stall,
  input  logic            cmt_stall,
  input  logic            cmt_squash,
  input  logic            cmt_rob_sq,
  input  logic [FRW-1:0]  rob_free,
  input  logic [FRW-1:0]  iq_free,
  input  logic [PW-1:0]   preg_free,
  output logic [CNTW-1:0] out_cnt,
  output logic [W*TW-1:0] out_tag,
  output logic            stall_dec,
  output logic [1:0]      mode
);
  rn_mode_e        st_q, st_d;
  logic [CNTW-1:0] idx_q, idx_d;
  logic            stall_q, stall_d;

  logic            sq_any, stl_any, dec_has;
  logic            skid_clr, skid_push, skid_pop;
  logic            emit;

  logic            cred_ok;
  logic [CNTW-1:0] cred_lim;

  logic [CNTW-1:0] hd_cnt;
  logic [W*TW-1:0] hd_tag;
  logic [W-1:0]    hd_sqd;
  logic [W*DW-1:0] hd_dst;
  logic [SCW-1:0]  skid_lvl;
  logic            skid_full, skid_empty;

  logic [CNTW-1:0] src_cnt;
  logic [W*TW-1:0] src_tag;
  logic [W-1:0]    src_sqd;
  logic [W*DW-1:0] src_dst;
  logic [CNTW-1:0] src_start;

  logic [CNTW-1:0] w_cnt;
  logic [W*TW-1:0] w_tag;
  logic [CNTW-1:0] w_stop;
  logic            w_done;
  logic            unblk_ok;

  assign sq_any   = cmt_squash | cmt_rob_sq;
  assign stl_any  = iew_stall | cmt_stall;
  assign dec_has  = (dec_cnt != '0);
  assign unblk_ok = !stl_any && cred_ok && (preg_free != '0);

  rn_credit #(.W(W), .DLY(DLY), .FRW(FRW), .CNTW(CNTW)) u_credit (
    .rob_free (rob_free),
    .iq_free  (iq_free),
    .cred_ok  (cred_ok),
    .cred_lim (cred_lim)
  );

  rn_skid #(.W(W), .TW(TW), .DW(DW), .CNTW(CNTW), .SKD(SKD)) u_skid (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (skid_clr),
    .push   (skid_push),
    .pop    (skid_pop),
    .in_cnt (dec_cnt),
    .in_tag (dec_tag),
    .in_sqd (dec_sqd),
    .in_dst (dec_dst),
    .hd_cnt (hd_cnt),
    .hd_tag (hd_tag),
    .hd_sqd (hd_sqd),
    .hd_dst (hd_dst),
    .level  (skid_lvl),
    .full   (skid_full),
    .empty  (skid_empty)
  );

  // Source select: stored head while unblocking, live decode otherwise.
  always_comb begin
    if (st_q == RN_UNB) begin
      src_cnt   = hd_cnt;
      src_tag   = hd_tag;
      src_sqd   = hd_sqd;
      src_dst   = hd_dst;
      src_start = idx_q;
    end else begin
      src_cnt   = dec_cnt;
      src_tag   = dec_tag;
      src_sqd   = dec_sqd;
      src_dst   = dec_dst;
      src_start = '0;
    end
  end

  rn_walk #(.W(W), .TW(TW), .DW(DW), .PW(PW), .CNTW(CNTW)) u_walk (
    .src_cnt   (src_cnt),
    .src_tag   (src_tag),
    .src_sqd   (src_sqd),
    .src_dst   (src_dst),
    .start_idx (src_start),
    .cred_lim  (cred_lim),
    .preg_free (preg_free),
    .emit_cnt  (w_cnt),
    .emit_tag  (w_tag),
    .stop_idx  (w_stop),
    .grp_done  (w_done)
  );

  // Next-state logic.
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    skid_clr  = 1'b0;
    skid_push = 1'b0;
    skid_pop  = 1'b0;
    emit      = 1'b0;
    unique case (st_q)
      RN_RUN, RN_SQ: begin
        if (sq_any) begin
          skid_clr = 1'b1;
          idx_d    = '0;
          st_d     = RN_SQ;
        end else if (stl_any) begin
          skid_push = dec_has;
          st_d      = RN_BLK;
        end else if (dec_has && !cred_ok) begin
          skid_push = 1'b1;
          idx_d     = '0;
          st_d      = RN_BLK;
        end else if (dec_has) begin
          emit = 1'b1;
          if (w_done) begin
            idx_d = '0;
            st_d  = RN_RUN;
          end else begin
            skid_push = 1'b1;
            idx_d     = w_stop;
            st_d      = RN_BLK;
          end
        end else begin
          st_d = RN_RUN;
        end
      end
      RN_BLK: begin
        if (sq_any) begin
          skid_clr = 1'b1;
          idx_d    = '0;
          st_d     = RN_SQ;
        end else begin
          skid_push = dec_has;
          if (unblk_ok) begin
            st_d = (skid_empty && !dec_has) ? RN_RUN : RN_UNB;
          end
        end
      end
      RN_UNB: begin
        if (sq_any) begin
          skid_clr = 1'b1;
          idx_d    = '0;
          st_d     = RN_SQ;
        end else begin
          skid_push = dec_has;
          if (stl_any || !cred_ok) begin
            st_d = RN_BLK;
          end else begin
            emit = 1'b1;
            if (w_done) begin
              skid_pop = 1'b1;
              idx_d    = '0;
              st_d     = ((skid_lvl == SCW'(1)) && !dec_has) ? RN_RUN : RN_UNB;
            end else begin
              idx_d = w_stop;
              st_d  = RN_BLK;
            end
          end
        end
      end
      default: st_d = RN_RUN;
    endcase
    stall_d = (st_d == RN_BLK) || (st_d == RN_UNB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RN_RUN;
      idx_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      stall_q <= stall_d;
    end
  end

  assign out_cnt   = emit ? w_cnt : '0;
  assign out_tag   = emit ? w_tag : '0;
  assign stall_dec = stall_q;
  assign mode      = st_q;
endmodule

// File: rtl/rn_stall_ctrl_chk.sv
module rn_stall_ctrl_chk #(
  parameter int W    = 4,
  parameter int DLY  = 1,
  parameter int SKD  = 4,
  parameter int FRW  = 6,
  parameter int CNTW = 3,
  parameter int SCW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic [CNTW-1:0] out_cnt,
  input logic            cmt_squash,
  input logic            cmt_rob_sq,
  input logic [FRW-1:0]  rob_free,
  input logic [FRW-1:0]  iq_free,
  input logic [SCW-1:0]  skid_lvl,
  input logic            skid_push,
  input logic            skid_pop
);
  a_r7_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (out_cnt == '0));

  a_r10_squash_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_squash || cmt_rob_sq) |-> (out_cnt == '0));

  a_r10_squash_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_squash || cmt_rob_sq) |=> (mode == 2'd3));

  a_r4_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt != '0) |-> ((int'(rob_free) - W*DLY >= int'(out_cnt)) &&
                         (int'(iq_free)  - W*DLY >= int'(out_cnt))));

  a_r2_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_cnt) <= W);

  a_r9_run_store_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (skid_lvl == '0));

  a_r9_unb_store_used: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (skid_lvl != '0));

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(skid_push && !skid_pop && (skid_lvl == SCW'(SKD))));
endmodule

bind rn_stall_ctrl rn_stall_ctrl_chk #(
  .W(W), .DLY(DLY), .SKD(SKD), .FRW(FRW), .CNTW(CNTW), .SCW(SCW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .out_cnt    (out_cnt),
  .cmt_squash (cmt_squash),
  .cmt_rob_sq (cmt_rob_sq),
  .rob_free   (rob_free),
  .iq_free    (iq_free),
  .skid_lvl   (skid_lvl),
  .skid_push  (skid_push),
  .skid_pop   (skid_pop)
);

// File: tb/rn_stall_ctrl_bench.sv
module rn_stall_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int W = 4, TW = 8, DW = 2, DLY = 1, SKD = 4, FRW = 6, PW = 6;
  localparam int CNTW = $clog2(W + 1);

  logic            clk;
  logic            rst_n;
  logic [CNTW-1:0] dec_cnt;
  logic [W*TW-1:0] dec_tag;
  logic [W-1:0]    dec_sqd;
  logic [W*DW-1:0] dec_dst;
  logic            iew_stall, cmt_stall, cmt_squash, cmt_rob_sq;
  logic [FRW-1:0]  rob_free, iq_free;
  logic [PW-1:0]   preg_free;
  logic [CNTW-1:0] out_cnt;
  logic [W*TW-1:0] out_tag;
  logic            stall_dec;
  logic [1:0]      mode;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  int next_tag = 1;
  int last_cnt;
  int last_tag [W];
  logic [TW-1:0] exp_q [$];

  rn_stall_ctrl #(.W(W), .TW(TW), .DW(DW), .DLY(DLY), .SKD(SKD), .FRW(FRW), .PW(PW)) u_rn_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_cnt(dec_cnt), .dec_tag(dec_tag), .dec_sqd(dec_sqd),
    .dec_dst(dec_dst), .iew_stall(iew_stall), .cmt_stall(cmt_stall),
    .cmt_squash(cmt_squash), .cmt_rob_sq(cmt_rob_sq), .rob_free(rob_free),
    .iq_free(iq_free), .preg_free(preg_free), .out_cnt(out_cnt), .out_tag(out_tag),
    .stall_dec(stall_dec), .mode(mode)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic grp(input int cnt, input logic [W-1:0] sqd, input logic [W*DW-1:0] dst,
                     output int base);
    base = next_tag;
    dec_cnt = CNTW'(cnt);
    dec_sqd = sqd;
    dec_dst = dst;
    dec_tag = '0;
    for (int i = 0; i < cnt; i++) dec_tag[i*TW +: TW] = TW'(next_tag + i);
    next_tag = next_tag + cnt;
  endtask

  task automatic idle();
    dec_cnt = '0;
    dec_tag = '0;
    dec_sqd = '0;
    dec_dst = '0;
  endtask

  // Called at a falling edge with inputs set; samples outputs, runs the
  // scoreboard (R11) and returns at the next falling edge.
  task automatic step();
    #1;
    for (int i = 0; i < int'(dec_cnt); i++)
      if (!dec_sqd[i]) exp_q.push_back(dec_tag[i*TW +: TW]);
    if (cmt_squash || cmt_rob_sq) exp_q.delete();
    last_cnt = int'(out_cnt);
    for (int i = 0; i < W; i++) last_tag[i] = int'(out_tag[i*TW +: TW]);
    for (int i = 0; i < last_cnt; i++) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11 actual=%0d expected=none", last_tag[i]);
      end else begin
        if (int'(exp_q[0]) != last_tag[i]) begin
          bad++;
          $display("FAIL R11 actual=%0d expected=%0d", last_tag[i], int'(exp_q[0]));
        end
        void'(exp_q.pop_front());
      end
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int b, b2;
    int sq_left;
    bit stall_prev;
    rst_n = 1'b0;
    idle();
    iew_stall = 0; cmt_stall = 0; cmt_squash = 0; cmt_rob_sq = 0;
    rob_free = 20; iq_free = 20; preg_free = 30;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 mode", int'(mode), 0);
    chk("R1 stall", int'(stall_dec), 0);
    chk("R1 out_cnt", int'(out_cnt), 0);
    @(negedge clk);

    // R2: full group passes in order
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R2 count", last_cnt, 4);
    chk("R2 first", last_tag[0], b);
    chk("R2 last", last_tag[3], b + 3);
    chk("R2 mode", int'(mode), 0);

    // R3: squashed slots dropped and use no credit
    grp(4, 4'b0010, 8'h55, b); step();
    chk("R3 count", last_cnt, 3);
    chk("R3 packing", last_tag[1], b + 2);
    rob_free = 6;
    grp(4, 4'b0011, 8'h55, b); step();
    chk("R3 credit count", last_cnt, 2);
    chk("R3 first live", last_tag[0], b + 2);
    chk("R3 no block", int'(mode), 0);
    rob_free = 20;

    // R4: no credit blocks at once
    rob_free = 4;
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R4 nothing", last_cnt, 0);
    chk("R4 mode", int'(mode), 1);
    chk("R12 stall", int'(stall_dec), 1);
    rob_free = 20;
    idle(); step();
    chk("R8 to unblock", int'(mode), 2);
    idle(); step();
    chk("R9 drained", last_cnt, 4);
    chk("R9 tag", last_tag[0], b);
    chk("R9 mode", int'(mode), 0);
    chk("R9 stall low", int'(stall_dec), 0);

    // R5: partial acceptance and resumption
    rob_free = 6;
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R5 partial", last_cnt, 2);
    chk("R5 mode", int'(mode), 1);
    rob_free = 20;
    idle(); step();
    idle(); step();
    chk("R5 resume count", last_cnt, 2);
    chk("R5 resume tag", last_tag[0], b + 2);
    chk("R5 mode", int'(mode), 0);

    // R6: register limit, destination counts 2,2,1,0
    preg_free = 3;
    grp(4, 4'b0000, 8'h1A, b); step();
    chk("R6 partial", last_cnt, 1);
    chk("R6 mode", int'(mode), 1);
    idle(); step();
    chk("R6 unblock", int'(mode), 2);
    idle(); step();
    chk("R6 resume count", last_cnt, 3);
    chk("R6 resume tag", last_tag[0], b + 1);
    preg_free = 30;

    // R7 / R8: stall, stored groups, unblock conditions
    iew_stall = 1;
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R7 silent", last_cnt, 0);
    chk("R7 mode", int'(mode), 1);
    grp(4, 4'b0000, 8'h55, b2); step();
    chk("R7 silent2", last_cnt, 0);
    iew_stall = 0; preg_free = 0;
    idle(); step();
    chk("R8 stays blocked", int'(mode), 1);
    preg_free = 30;
    idle(); step();
    chk("R8 unblock", int'(mode), 2);
    idle(); step();
    chk("R9 first group", last_tag[0], b);
    chk("R9 still unblocking", int'(mode), 2);
    chk("R9 stall held", int'(stall_dec), 1);
    idle(); step();
    chk("R9 second group", last_tag[0], b2);
    chk("R9 back to run", int'(mode), 0);

    // R10: squash discards stored work
    cmt_stall = 1;
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R10 blocked", int'(mode), 1);
    cmt_stall = 0; cmt_squash = 1;
    idle(); step();
    chk("R10 silent", last_cnt, 0);
    chk("R10 mode", int'(mode), 3);
    cmt_squash = 0; cmt_rob_sq = 1;
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R10 dropped", last_cnt, 0);
    chk("R10 held", int'(mode), 3);
    cmt_rob_sq = 0;
    grp(4, 4'b0000, 8'h55, b); step();
    chk("R10 release count", last_cnt, 4);
    chk("R10 release tag", last_tag[0], b);
    chk("R10 run", int'(mode), 0);
    idle(); step();
    chk("R10 store cleared", last_cnt, 0);

    // Random stalls, starvation and squashes; decode sees stall one cycle late
    sq_left = 0;
    stall_prev = 0;
    for (int c = 0; c < 400; c++) begin
      bit s_now;
      s_now = stall_dec;
      iew_stall = (($urandom % 8) == 0);
      cmt_stall = (($urandom % 12) == 0);
      if (sq_left == 0 && ($urandom % 40) == 0) begin
        sq_left = 1 + ($urandom % 3);
        cmt_squash = 1; cmt_rob_sq = 0;
      end else if (sq_left > 0) begin
        cmt_squash = 0; cmt_rob_sq = 1;
      end else begin
        cmt_squash = 0; cmt_rob_sq = 0;
      end
      if (sq_left > 0) sq_left--;
      rob_free  = FRW'(2 + ($urandom % 20));
      iq_free   = FRW'(2 + ($urandom % 20));
      preg_free = PW'($urandom % 8);
      if (!stall_prev && ($urandom % 4) != 0) begin
        logic [W*DW-1:0] d;
        for (int i = 0; i < W; i++) d[i*DW +: DW] = DW'($urandom % 3);
        grp(1 + ($urandom % W), W'(($urandom % 4 == 0) ? $urandom : 0), d, b);
      end else begin
        idle();
      end
      stall_prev = s_now;
      step();
    end

    // Drain: everything owed must come out (R11)
    iew_stall = 0; cmt_stall = 0; cmt_squash = 0; cmt_rob_sq = 0;
    rob_free = 20; iq_free = 20; preg_free = 30;
    idle();
    repeat (20) step();
    chk("R11 nothing lost", exp_q.size(), 0);
    chk("R9 final mode", int'(mode), 0);
    chk("R12 final stall", int'(stall_dec), 0);

    finish_run();
  end
endmodule